// File: doc/BRIEF.md
# Synchronizable Counter-Compare Pulse-Width Modulator

This block produces a pulse-width modulated output from a duty fraction. A free-running counter steps through one switching period and returns to zero at its end. At each return to zero the block multiplies the current duty fraction by the current period and takes the integer part as the compare threshold. The output is high while the counter is below that threshold. The duty and the period are sampled only at the start of a period, so a change made in the middle of a period cannot cut a pulse short or lengthen it.

Several instances can share one phase. Each instance drives a one-clock pulse on `sync_o` at the start of every period. When following is enabled, a rising edge on `sync_i` restarts the period of the instance on the next clock edge. Chaining `sync_o` of a leader into `sync_i` of a follower locks the two periods together. An external timing signal can drive `sync_i` in the same way.

Top module: `sync_dpwm`

## Requirements
- R1: `duty_i` is an unsigned fraction scaled by 2^DUTY_W (4096 by default), so 2048 means one half. Any value above 2^DUTY_W is treated as exactly 2^DUTY_W. The compare threshold is floor(duty × period / 2^DUTY_W).
- R2: A period lasts exactly P clocks, where P is the period in effect. During a period `pwm_o` is high for the first `threshold` clocks and low for the rest.
- R3: A duty of 0 keeps `pwm_o` low for the whole period. A duty of 2^DUTY_W or more keeps it high for the whole period.
- R4: A `period_i` value of 0 or 1 is treated as a period of 2 clocks.
- R5: `duty_i` and `period_i` are sampled only on the clock edge that starts a period. A change made during a period takes effect at the next period start.
- R6: `sync_o` is high for exactly one clock, which is the first clock of every period.
- R7: When `sync_en_i` is high, a rising edge on `sync_i` that is seen at a clock edge restarts the period at that same edge, so `sync_o` pulses in the following clock. Holding `sync_i` high does not restart the period again.
- R8: When `sync_en_i` is low, `sync_i` has no effect on period timing.
- R9: While `rst_n` is low, `pwm_o` and `sync_o` are low and the counter is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| duty_i | input | DUTY_W+1 | Duty fraction scaled by 2^DUTY_W |
| period_i | input | PER_W | Switching period in clocks (minimum 2) |
| sync_en_i | input | 1 | Lets a rising edge on `sync_i` restart the period |
| sync_i | input | 1 | Sync input from a leader or an external source |
| pwm_o | output | 1 | Modulated output |
| sync_o | output | 1 | One-clock pulse at the start of each period |

## Verification
The main function is tried with a table of duty and period pairs:
- half and quarter duties, which check the multiply and the truncation;
- duties just below full scale, which check that the result rounds down and never reaches the period;
- zero, full scale and above full scale, which check the constant and clamped outputs;
- period values of 0, 1 and 2, which separate the minimum-period rule from an ordinary short period;
- the largest period, which checks that the product does not overflow.

For every pair the bench measures the length of a whole period, the number of high clocks and whether the high clocks are contiguous from the start. Directed runs then cover the following:
- a change of duty and period in the middle of a period;
- a sync edge with following enabled, and the same edge with following disabled;
- a sync input held high, which must not restart the period again;
- a reset in the middle of a period.

// File: rtl/sync_dpwm.sv
module sync_dpwm #(
  parameter int PER_W   = 12,
  parameter int DUTY_W  = 12,
  parameter int MIN_PER = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W:0]   duty_i,
  input  logic [PER_W-1:0]  period_i,
  input  logic              sync_en_i,
  input  logic              sync_i,
  output logic              pwm_o,
  output logic              sync_o
);
  localparam logic [DUTY_W:0]  FULL   = (DUTY_W+1)'(1) << DUTY_W;
  localparam logic [PER_W-1:0] PMIN   = PER_W'(MIN_PER);
  localparam int               PROD_W = DUTY_W + 1 + PER_W;

  logic [PER_W-1:0]  cnt, per_q, thr_q, per_eff, thr_new;
  logic [DUTY_W:0]   duty_sat;
  logic [PROD_W-1:0] prod;
  logic              sync_q, sync_rise, wrap, restart;

  assign per_eff   = (period_i < PMIN) ? PMIN : period_i;
  assign duty_sat  = (duty_i > FULL) ? FULL : duty_i;
  assign prod      = PROD_W'(duty_sat) * PROD_W'(per_eff);
  assign thr_new   = prod[DUTY_W +: PER_W];

  assign sync_rise = sync_en_i & sync_i & ~sync_q;
  assign wrap      = cnt >= per_q - PER_W'(1);
  assign restart   = wrap | sync_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      per_q  <= PMIN;
      thr_q  <= '0;
      sync_q <= 1'b0;
      sync_o <= 1'b0;
    end else begin
      sync_q <= sync_i;
      sync_o <= restart;
      if (restart) begin
        cnt   <= '0;
        per_q <= per_eff;
        thr_q <= thr_new;
      end else begin
        cnt   <= cnt + PER_W'(1);
      end
    end
  end

  assign pwm_o = cnt < thr_q;

  a_r2_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < per_q);
  a_r4_period_floor: assert property (@(posedge clk) disable iff (!rst_n)
    per_q >= PMIN);
  a_r1_thr_within_period: assert property (@(posedge clk) disable iff (!rst_n)
    thr_q <= per_q);
  a_r5_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_o |-> ($stable(thr_q) && $stable(per_q)));
  a_r6_sync_single: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |=> !sync_o);
  a_r6_sync_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |-> cnt == '0);
  a_r3_zero_duty_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_o && $past(duty_i) == '0) |-> !pwm_o);
  a_r3_full_duty_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_o && $past(duty_i) >= FULL) |-> pwm_o);
  a_r7_sync_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_en_i && sync_i && !sync_q) |=> sync_o);
  a_r8_sync_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_en_i && cnt < per_q - PER_W'(1)) |=> !sync_o);
endmodule

// File: tb/sync_dpwm_test.sv
module sync_dpwm_test;
  localparam int PER_W = 12, DUTY_W = 12, NV = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DUTY_W:0]  duty = '0;
  logic [PER_W-1:0] period = 12'd10;
  logic sync_en = 1'b0, sync_in = 1'b0;
  logic pwm, sync_out;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  sync_dpwm #(.PER_W(PER_W), .DUTY_W(DUTY_W)) uut (
    .clk(clk), .rst_n(rst_n), .duty_i(duty), .period_i(period),
    .sync_en_i(sync_en), .sync_i(sync_in), .pwm_o(pwm), .sync_o(sync_out));

  always #2.5 clk = ~clk;

  // duty, period, expected length, expected high clocks
  localparam int VEC [NV][4] = '{
    '{2048, 100, 100,   50},   // R1 half
    '{1024,  10,  10,    2},   // R1 truncation
    '{4095,   7,   7,    6},   // R1 just below full
    '{   0,  50,  50,    0},   // R3 zero
    '{4096,  40,  40,   40},   // R3 full
    '{5000,  30,  30,   30},   // R1 clamp
    '{ 100,   0,   2,    0},   // R4 period 0
    '{3000,   1,   2,    1},   // R4 period 1
    '{4096,   2,   2,    2},   // R4 period 2
    '{   1,4095,4095,    0},   // R1 tiny duty
    '{4095,4095,4095, 4094},   // R1 largest
    '{ 768,  16,  16,    3}    // R2 ordering
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_start();
    @(negedge clk);
    while (!sync_out && !done) @(negedge clk);
  endtask

  // called at a negedge where sync_out is high
  task automatic measure(output int len, output int high, output bit contig);
    bit seen_low = 0;
    len = 0; high = 0; contig = 1;
    do begin
      if (pwm) begin
        high++;
        if (seen_low) contig = 0;
      end else seen_low = 1;
      len++;
      @(negedge clk);
    end while (!sync_out && len < 5000 && !done);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      check(0, "watchdog", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int len, high;
    bit contig;
    repeat (3) @(negedge clk);
    check(pwm == 0, "R9 pwm in reset", pwm, 0);
    check(sync_out == 0, "R9 sync in reset", sync_out, 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      duty = (DUTY_W+1)'(VEC[v][0]);
      period = PER_W'(VEC[v][1]);
      wait_start();
      measure(len, high, contig);
      check(len == VEC[v][2], $sformatf("R2/R4 length v%0d", v), len, VEC[v][2]);
      check(high == VEC[v][3], $sformatf("R1/R3 high v%0d", v), high, VEC[v][3]);
      check(contig, $sformatf("R2 contiguous v%0d", v), contig, 1);
    end

    // R5: mid-period change waits for the next period
    @(negedge clk); duty = 13'd2048; period = 12'd100;
    wait_start();
    @(negedge clk); duty = '0; period = 12'd20;
    while (!sync_out) @(negedge clk);
    @(negedge clk); duty = 13'd2048; period = 12'd100;
    wait_start();
    repeat (3) @(negedge clk);
    duty = '0; period = 12'd20;
    len = 3; high = 3;
    do begin if (pwm) high++; len++; @(negedge clk); end while (!sync_out && len < 5000);
    check(len == 100, "R5 old period kept", len, 100);
    check(high == 50, "R5 old duty kept", high, 50);
    measure(len, high, contig);
    check(len == 20 && high == 0, "R5 new values applied", len * 1000 + high, 20000);

    // R7: enabled sync edge restarts, held level does not
    period = 12'd100; duty = 13'd2048; sync_en = 1'b1;
    wait_start(); wait_start();
    repeat (10) @(negedge clk);
    sync_in = 1'b1;
    @(negedge clk);
    check(sync_out == 1, "R7 restart after edge", sync_out, 1);
    measure(len, high, contig);
    check(len == 100, "R7 held level no retrigger", len, 100);
    sync_in = 1'b0;

    // R8: disabled sync edge ignored
    sync_en = 1'b0;
    wait_start();
    len = 0;
    do begin
      if (len == 10) sync_in = 1'b1;
      len++;
      @(negedge clk);
    end while (!sync_out && len < 5000);
    check(len == 100, "R8 sync ignored", len, 100);
    sync_in = 1'b0;

    // R6: sync pulse lasts one clock
    @(negedge clk);
    check(sync_out == 0, "R6 one-clock sync", sync_out, 0);

    // R9: reset mid-period
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(pwm == 0 && sync_out == 0, "R9 mid-run reset", {pwm, sync_out}, 0);
    rst_n = 1'b1;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule